// File: doc/BRIEF.md
# Configurable Eight-Pin GPIO Output Stage

This block is the control core of a general-purpose I/O port with eight pins. Software sets it up through a small word-wide register bus. Each pin has a two-bit mode: plain input, push-pull output, open-drain, or quasi-bidirectional. A shared output-data register holds the level each pin should take. A per-pin write-protect mask shields chosen data bits from later software writes. A per-pin input-path cut-off forces a pin's sampled level low. A read-only location returns the live pin levels after that gating.

The block does not model the pad electrically. It produces three control vectors for the pad ring: drive enable, drive value and weak pull-up enable. It takes back the raw pad input levels. Register writes take effect on the next rising clock edge. The pad controls and read data follow from the registers with no further delay: reads are combinational from the address. The bus is always ready and has no back-pressure. A write is accepted in every cycle its write enable is high, and read data is valid in the same cycle as the address.

Top module: `pio_bank`

## Requirements
- R1: After reset every register reads 0. Every pin is therefore an input with its input path enabled and no data bits protected, and `pad_oe`, `pad_out` and `pad_pullup` are all 0.
- R2: Pin n's mode sits in bits [2n+1:2n] of the word at byte offset 0x00, with 00 = input, 01 = push-pull, 10 = open-drain and 11 = quasi-bidirectional. The word reads back with bits [31:16] as 0.
- R3: A pin in input mode has its drive enable and its pull-up both at 0.
- R4: A pin in push-pull mode has its drive enable at 1 and its drive value equal to its output-data bit.
- R5: A pin in open-drain mode drives low (enable 1, value 0) when its data bit is 0. It is released (enable 0) with no pull-up when its data bit is 1.
- R6: A pin in quasi-bidirectional mode drives low when its data bit is 0. When its data bit is 1 it is released with the weak pull-up at 1. The pull-up is never 1 while the pin is driven.
- R7: The output data is in bits [7:0] at offset 0x08, and the write-protect mask is in bits [7:0] at offset 0x0C. A write to 0x08 changes only the data bits whose mask bit is 0. Both words read back with bits [31:8] as 0.
- R8: The input-path cut-off is in bits [23:16] at offset 0x04. A 1 in bit 16+n forces pin n's sampled level to 0. The word reads back with all other bits as 0.
- R9: Offset 0x10 returns the live pad levels after the cut-off in bits [7:0], with bits [31:8] as 0. Writes to 0x10 change no register.
- R10: Reads of any other byte address return 0, and writes to any other byte address change no register.
- R11: `pad_out` is 0 for every pin whose drive enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable; the write lands on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad drive enable per pin |
| pad_out | output | 8 | Pad drive value per pin |
| pad_pullup | output | 8 | Weak pull-up enable per pin |

## Verification
The mode decoder is tried with a mode word that gives each of the four modes to two pins. It is run against data 0xAA and then 0x55, so every mode is seen with both data values. This tells a swapped mode code apart from a pin that ignores its data bit, and a quasi pull-up apart from an open-drain release. The write mask is tried with a half mask, which shows whether protected bits hold while unprotected bits take new values, and then with no mask. The input path is tried with two complementary pad patterns against a partial cut-off. This shows both the gating and that the value read is live. Writes of all ones to the read-only and unmapped addresses are followed by read-back of every register, to show that nothing was disturbed.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PM_IN     = 2'b00,
    PM_PUSH   = 2'b01,
    PM_ODRAIN = 2'b10,
    PM_QUASI  = 2'b11
  } pin_mode_e;

  localparam int unsigned OFF_MODE = 'h00;
  localparam int unsigned OFF_CUT  = 'h04;
  localparam int unsigned OFF_DATA = 'h08;
  localparam int unsigned OFF_MASK = 'h0C;
  localparam int unsigned OFF_PINS = 'h10;
  localparam int unsigned CUT_LSB  = 16;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pad_ctl_t;

  function automatic pad_ctl_t pad_ctl(input pin_mode_e m, input logic d);
    pad_ctl_t c;
    c = '0;
    unique case (m)
      PM_IN:     c = '0;
      PM_PUSH:   begin c.oe = 1'b1; c.out = d; end
      PM_ODRAIN: c.oe = ~d;
      PM_QUASI:  begin c.oe = ~d; c.pu = d; end
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [2*NPIN-1:0] mode_q,
  output logic [NPIN-1:0]   cut_q,
  output logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   mask_q
);
  localparam int MODE_W = 2 * NPIN;
  localparam int USED_W = CUT_LSB + NPIN;

  logic wr_mode, wr_cut, wr_data, wr_mask;
  logic unused_wdata;

  assign wr_mode = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
  assign wr_cut  = bus_we && (bus_addr == ADDR_W'(OFF_CUT));
  assign wr_data = bus_we && (bus_addr == ADDR_W'(OFF_DATA));
  assign wr_mask = bus_we && (bus_addr == ADDR_W'(OFF_MASK));
  assign unused_wdata = ^bus_wdata[DW-1:USED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cut_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
      if (wr_cut)  cut_q  <= bus_wdata[CUT_LSB +: NPIN];
      if (wr_mask) mask_q <= bus_wdata[NPIN-1:0];
      if (wr_data) data_q <= (data_q & mask_q) | (bus_wdata[NPIN-1:0] & ~mask_q);
    end
  end
endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive
  import pio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [2*NPIN-1:0] mode_q,
  input  logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_pullup
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pad_ctl_t ctl;
    assign ctl           = pad_ctl(pin_mode_e'(mode_q[2*i +: 2]), data_q[i]);
    assign pad_oe[i]     = ctl.oe;
    assign pad_out[i]    = ctl.out;
    assign pad_pullup[i] = ctl.pu;
  end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2*NPIN-1:0] mode_q,
  input  logic [NPIN-1:0]   cut_q,
  input  logic [NPIN-1:0]   data_q,
  input  logic [NPIN-1:0]   mask_q,
  input  logic [NPIN-1:0]   pad_in,
  output logic [DW-1:0]     bus_rdata
);
  logic [NPIN-1:0] pin_lvl;

  assign pin_lvl = pad_in & ~cut_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_MODE))      bus_rdata[2*NPIN-1:0]      = mode_q;
    else if (bus_addr == ADDR_W'(OFF_CUT))  bus_rdata[CUT_LSB +: NPIN] = cut_q;
    else if (bus_addr == ADDR_W'(OFF_DATA)) bus_rdata[NPIN-1:0]        = data_q;
    else if (bus_addr == ADDR_W'(OFF_MASK)) bus_rdata[NPIN-1:0]        = mask_q;
    else if (bus_addr == ADDR_W'(OFF_PINS)) bus_rdata[NPIN-1:0]        = pin_lvl;
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_pullup
);
  logic [2*NPIN-1:0] mode_q;
  logic [NPIN-1:0]   cut_q;
  logic [NPIN-1:0]   data_q;
  logic [NPIN-1:0]   mask_q;

  pio_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .mode_q    (mode_q),
    .cut_q     (cut_q),
    .data_q    (data_q),
    .mask_q    (mask_q)
  );

  pio_pad_drive #(.NPIN(NPIN)) u_drive (
    .mode_q     (mode_q),
    .data_q     (data_q),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pullup (pad_pullup)
  );

  pio_rd_mux #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DW(DW)) u_rd (
    .bus_addr  (bus_addr),
    .mode_q    (mode_q),
    .cut_q     (cut_q),
    .data_q    (data_q),
    .mask_q    (mask_q),
    .pad_in    (pad_in),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_rdata,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_pullup,
  input logic [2*NPIN-1:0] mode_q,
  input logic [NPIN-1:0]   cut_q,
  input logic [NPIN-1:0]   data_q,
  input logic [NPIN-1:0]   mask_q
);
  logic data_wr;
  assign data_wr = bus_we && (bus_addr == ADDR_W'('h08));

  p_no_pull_while_driving_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pullup) == '0);

  p_out_low_when_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  p_masked_bits_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((data_q ^ $past(data_q)) & $past(mask_q)) == '0);

  p_data_only_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(data_q));

  p_pin_value_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h10)) |-> bus_rdata == DW'(pad_in & ~cut_q));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b00) |-> (!pad_oe[i] && !pad_pullup[i]));

    p_push_follows_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b01) |-> (pad_oe[i] && pad_out[i] == data_q[i]));

    p_odrain_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b10) |-> (pad_oe[i] == !data_q[i] && !pad_pullup[i]));

    p_quasi_pullup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b11) |-> (pad_oe[i] == !data_q[i] && pad_pullup[i] == data_q[i]));
  end
endmodule

bind pio_bank pio_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .pad_in     (pad_in),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pullup (pad_pullup),
  .mode_q     (mode_q),
  .cut_q      (cut_q),
  .data_q     (data_q),
  .mask_q     (mask_q)
);

// File: tb/test_pio_bank.sv
`timescale 1ns/1ps
module test_pio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out, pad_pullup;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_bank i_pio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  // Expected pad controls from the mode and data rules (R3..R6, R11)
  task automatic exp_pads(input logic [15:0] m, input logic [7:0] d,
                          output logic [7:0] oe, output logic [7:0] o, output logic [7:0] pu);
    oe = '0; o = '0; pu = '0;
    for (int i = 0; i < 8; i++) begin
      case (m[2*i +: 2])
        2'b01: begin oe[i] = 1'b1; o[i] = d[i]; end
        2'b10: oe[i] = ~d[i];
        2'b11: begin oe[i] = ~d[i]; pu[i] = d[i]; end
        default: ;
      endcase
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
    chk("R1 pad_pullup", {24'h0, pad_pullup}, 32'h0);
    rd(8'h00, v); chk("R1 mode reg", v, 32'h0);
    rd(8'h04, v); chk("R1 cut reg", v, 32'h0);
    rd(8'h08, v); chk("R1 data reg", v, 32'h0);
    rd(8'h0C, v); chk("R1 mask reg", v, 32'h0);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    logic [7:0] eoe, eo, epu;
    logic [15:0] m = 16'hFA50; // pins 0,1 in; 2,3 push; 4,5 od; 6,7 quasi
    wr(8'h00, 32'hFFFF_FA50);
    rd(8'h00, v); chk("R2 mode readback", v, 32'h0000_FA50);
    foreach (m[k]) ; // no-op keeps m referenced uniformly
    for (int p = 0; p < 2; p++) begin
      logic [7:0] d = (p == 0) ? 8'hAA : 8'h55;
      wr(8'h08, {24'hFFFFFF, d});
      #1;
      exp_pads(m, d, eoe, eo, epu);
      chk("R3 R4 R5 R6 pad_oe", {24'h0, pad_oe}, {24'h0, eoe});
      chk("R4 pad_out", {24'h0, pad_out}, {24'h0, eo});
      chk("R6 pad_pullup", {24'h0, pad_pullup}, {24'h0, epu});
      chk("R11 out low when released", {24'h0, pad_out & ~pad_oe}, 32'h0);
    end
    rd(8'h08, v); chk("R7 data readback", v, 32'h55);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h08, 32'h00);
    wr(8'h0C, 32'hFFFF_FFF0);
    rd(8'h0C, v); chk("R7 mask readback", v, 32'hF0);
    wr(8'h08, 32'hFF);
    rd(8'h08, v); chk("R7 masked bits held", v, 32'h0F);
    wr(8'h08, 32'h30);
    rd(8'h08, v); chk("R7 unmasked bits cleared", v, 32'h00);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h3C);
    rd(8'h08, v); chk("R7 no mask write", v, 32'h3C);
  endtask

  task automatic t_pins();
    logic [31:0] v;
    pad_in = 8'hA5;
    rd(8'h10, v); chk("R9 pin value open", v, 32'hA5);
    wr(8'h04, 32'hFF0F_FFFF);
    rd(8'h04, v); chk("R8 cut readback", v, 32'h000F_0000);
    rd(8'h10, v); chk("R8 cut gates pins", v, 32'hA0);
    pad_in = 8'h5A;
    rd(8'h10, v); chk("R9 pin value live", v, 32'h50);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R9 write ignored", v, 32'h50);
    rd(8'h04, v); chk("R9 cut untouched", v, 32'h000F_0000);
    wr(8'h04, 32'h0);
    rd(8'h10, v); chk("R8 cut released", v, 32'h5A);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R10 read 0x14", v, 32'h0);
    rd(8'h0A, v); chk("R10 read 0x0A", v, 32'h0);
    rd(8'hFC, v); chk("R10 read 0xFC", v, 32'h0);
    rd(8'h00, v); chk("R10 mode untouched", v, 32'h0000_FA50);
    rd(8'h08, v); chk("R10 data untouched", v, 32'h3C);
    rd(8'h0C, v); chk("R10 mask untouched", v, 32'h0);
    rd(8'h04, v); chk("R10 cut untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_modes();
    t_mask();
    t_pins();
    t_unmapped();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule